// File: doc/BRIEF.md
# Serial Write Block Address Loader

This block controls the write pointer of a large serial field memory. The pointer normally advances by one word on every write-clock edge where write enable is high. It can also be moved straight to the start of any 40-word block. To do that, the host raises the write-reset line. That starts a sequence that counts a fixed number of write-clock edges. A 13-bit block number then arrives serially, most significant bit first, on one pin that the host chooses: either data bit 0 or the input-enable pin. An 18-cycle latency follows, and then the pointer moves to the start of the chosen block.

The level of write enable on the fifth edge of the sequence selects the address pin. While the sequence runs, the block checks that write enable stays inside its allowed windows. It pulses a violation output when a rule is broken. It refuses block numbers beyond the last block and raises an error flag for them. A second rising edge on write reset during the sequence cancels the sequence and returns the pointer to word 0.

The edges of a sequence are numbered from 1. Edge 1 is the clock edge at which the rising edge of write reset is seen.

Top module: `blk_addr_loader`

## Requirements
- R1: While synchronous reset is high, and after it is released, busy, pinSelIe, timingViol and addrErr are 0 and wrPtr is 0.
- R2: When idle, a write-reset level of 1 at an edge, after a 0 at the previous edge, is edge 1 of a sequence. busy is high after edges 1 to 34 and low after edge 35 (the 18th latency cycle after the last address bit).
- R3: The address pin is chosen by write enable at edge 5: 1 selects ie and 0 selects d0. pinSelIe shows this choice from edge 5 until the next sequence starts.
- R4: The 13 address bits are sampled on the chosen pin at edges 5 to 17. The most significant bit comes first.
- R5: At edge 35, a block number from 0 to 6143 sets wrPtr to block × 40.
- R6: At edge 35, a block number of 6144 or more sets addrErr to 1 and leaves wrPtr unchanged. addrErr stays at 1 until the next sequence starts, and edge 1 clears it.
- R7: With d0 selected, timingViol pulses for one cycle after edge 5 if write enable was high at edge 3 or 4. It also pulses after any edge from 6 to 34 at which write enable is high.
- R8: With ie selected, timingViol pulses after any edge from 7 to 34 at which write enable is high. Write enable at edges 3, 4 and 6 causes no pulse.
- R9: A write-reset rising edge seen during a sequence (edge 3 or later) ends the sequence. busy goes low and wrPtr goes to 0 after that edge, and no block load takes place.
- R10: When idle, wrPtr advances by one after each edge where write enable is high. It wraps from 245759 to 0.
- R11: Write enable does not move wrPtr from edge 1 to edge 35 of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial write clock |
| rst | input | 1 | Synchronous reset, active high |
| wrRst | input | 1 | Write reset line. A rising edge starts a sequence, or cancels one that is running |
| we | input | 1 | Write enable |
| ie | input | 1 | Input enable. Can carry the address serially |
| d0 | input | 1 | Data bit 0. Can carry the address serially |
| busy | output | 1 | High while a block-address sequence runs |
| pinSelIe | output | 1 | 1 when the address is taken from ie, 0 when it is taken from d0 |
| timingViol | output | 1 | One-cycle pulse when a write-enable window rule is broken |
| addrErr | output | 1 | The last sequence delivered a block number out of range |
| wrPtr | output | 18 | Word write pointer |

## Verification
Every result is registered, so it shows after the same edge that caused it. The bench drives inputs 2 ns after a rising edge and reads the outputs 2 ns after the next rising edge. Busy, pinSelIe and any violation pulse are read after each numbered edge. The loaded pointer and the error flag are read after edge 35. A cancelling edge is judged by the outputs right after it.

// File: rtl/blk_addr_pkg.sv
package blk_addr_pkg;
  // Strobes from the sequence control to the pointer datapath.
  typedef struct packed {
    logic seqStart;  // edge 1 of a block-address sequence
    logic stdReset;  // cancelling write-reset edge
    logic shiftEn;   // sample one address bit
    logic shiftBit;  // the bit taken from the chosen pin
    logic loadReq;   // latency done: load the block start
    logic incEn;     // normal pointer advance
  } ctrlStrobes_t;
endpackage

// File: rtl/blk_addr_ctrl.sv
module blk_addr_ctrl
  import blk_addr_pkg::*;
#(
  parameter int ADDR_W         = 13,
  parameter int FIRST_BIT_EDGE = 5,
  parameter int LAT_CYCLES     = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wrRst,
  input  logic         we,
  input  logic         ie,
  input  logic         d0,
  output ctrlStrobes_t st,
  output logic         busy,
  output logic         pinSelIe,
  output logic         timingViol
);
  localparam int LSB_EDGE  = FIRST_BIT_EDGE + ADDR_W - 1;
  localparam int DONE_EDGE = LSB_EDGE + LAT_CYCLES;
  localparam int CNT_W     = $clog2(DONE_EDGE + 2);
  localparam logic [CNT_W-1:0] C_EARLY0 = CNT_W'(FIRST_BIT_EDGE - 2);
  localparam logic [CNT_W-1:0] C_EARLY1 = CNT_W'(FIRST_BIT_EDGE - 1);
  localparam logic [CNT_W-1:0] C_FIRST  = CNT_W'(FIRST_BIT_EDGE);
  localparam logic [CNT_W-1:0] C_IE_LOW = CNT_W'(FIRST_BIT_EDGE + 2);
  localparam logic [CNT_W-1:0] C_LSB    = CNT_W'(LSB_EDGE);
  localparam logic [CNT_W-1:0] C_WE_END = CNT_W'(DONE_EDGE - 1);
  localparam logic [CNT_W-1:0] C_DONE   = CNT_W'(DONE_EDGE);
  localparam logic [CNT_W-1:0] C_TWO    = CNT_W'(2);

  logic             wrRstPrev;
  logic             busyQ;
  logic [CNT_W-1:0] edgeCnt;   // number of the edge being processed
  logic             selIeQ;
  logic             earlyWeQ;
  logic             vioQ;
  logic             rise;
  logic             curSelIe;
  logic             vioNow;

  always_ff @(posedge clk) wrRstPrev <= wrRst;

  always_comb begin
    rise     = wrRst & ~wrRstPrev;
    curSelIe = (edgeCnt == C_FIRST) ? we : selIeQ;

    st.seqStart = rise && !busyQ;
    st.stdReset = rise && busyQ;
    st.shiftEn  = busyQ && !rise && (edgeCnt >= C_FIRST) && (edgeCnt <= C_LSB);
    st.shiftBit = curSelIe ? ie : d0;
    st.loadReq  = busyQ && !rise && (edgeCnt == C_DONE);
    st.incEn    = we && !busyQ && !rise;

    vioNow = 1'b0;
    if (busyQ && !rise) begin
      if (!curSelIe && edgeCnt == C_FIRST && earlyWeQ)
        vioNow = 1'b1;
      if (!selIeQ && edgeCnt > C_FIRST && edgeCnt <= C_WE_END && we)
        vioNow = 1'b1;
      if (selIeQ && edgeCnt >= C_IE_LOW && edgeCnt <= C_WE_END && we)
        vioNow = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busyQ    <= 1'b0;
      edgeCnt  <= '0;
      selIeQ   <= 1'b0;
      earlyWeQ <= 1'b0;
      vioQ     <= 1'b0;
    end else begin
      vioQ <= vioNow;
      if (st.seqStart) begin
        busyQ    <= 1'b1;
        edgeCnt  <= C_TWO;
        selIeQ   <= 1'b0;
        earlyWeQ <= 1'b0;
      end else if (st.stdReset) begin
        busyQ   <= 1'b0;
        edgeCnt <= '0;
      end else if (busyQ) begin
        edgeCnt <= edgeCnt + CNT_W'(1);
        if ((edgeCnt == C_EARLY0 || edgeCnt == C_EARLY1) && we)
          earlyWeQ <= 1'b1;
        if (edgeCnt == C_FIRST)
          selIeQ <= we;
        if (edgeCnt == C_DONE) begin
          busyQ   <= 1'b0;
          edgeCnt <= '0;
        end
      end
    end
  end

  assign busy       = busyQ;
  assign pinSelIe   = selIeQ;
  assign timingViol = vioQ;

  // R7, R8: a violation is only ever reported inside a running sequence
  p_vio_in_seq_r7: assert property (@(posedge clk) disable iff (rst)
    timingViol |-> busy);

  // R2: a sequence begins only on a low-to-high step of write reset
  p_start_on_rise_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(wrRst) && !$past(wrRst, 2)));

  // R3: the pin choice holds for the rest of the sequence
  p_sel_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && edgeCnt > C_IE_LOW) |-> $stable(pinSelIe));
endmodule

// File: rtl/blk_addr_dpath.sv
module blk_addr_dpath
  import blk_addr_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int BLOCK_WORDS = 40,
  parameter int NUM_BLOCKS  = 6144,
  parameter int PTR_W       = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobes_t     st,
  output logic [PTR_W-1:0] wrPtr,
  output logic             addrErr
);
  localparam int TOTAL_WORDS = NUM_BLOCKS * BLOCK_WORDS;
  localparam logic [PTR_W-1:0]  C_LAST   = PTR_W'(TOTAL_WORDS - 1);
  localparam logic [PTR_W-1:0]  C_BWORDS = PTR_W'(BLOCK_WORDS);
  localparam logic [ADDR_W:0]   C_NBLK   = (ADDR_W + 1)'(NUM_BLOCKS);

  logic [ADDR_W-1:0] addrSh;
  logic [PTR_W-1:0]  ptrQ;
  logic              errQ;
  logic [PTR_W-1:0]  blockBase;
  logic              addrOk;

  always_comb begin
    blockBase = PTR_W'(addrSh) * C_BWORDS;
    addrOk    = {1'b0, addrSh} < C_NBLK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addrSh <= '0;
      ptrQ   <= '0;
      errQ   <= 1'b0;
    end else begin
      if (st.seqStart) begin
        errQ   <= 1'b0;
        addrSh <= '0;
      end
      if (st.shiftEn)
        addrSh <= {addrSh[ADDR_W-2:0], st.shiftBit};
      if (st.stdReset)
        ptrQ <= '0;
      else if (st.loadReq) begin
        if (addrOk) ptrQ <= blockBase;
        else        errQ <= 1'b1;
      end else if (st.incEn)
        ptrQ <= (ptrQ == C_LAST) ? '0 : ptrQ + PTR_W'(1);
    end
  end

  assign wrPtr   = ptrQ;
  assign addrErr = errQ;

  // R10: the pointer never leaves the array
  p_ptr_range_r10: assert property (@(posedge clk) disable iff (rst)
    wrPtr <= C_LAST);

  // R6: a rejected block number leaves the pointer where it was
  p_err_noload_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(addrErr) |-> $stable(wrPtr));

  // R5: an accepted load lands on a block boundary
  p_load_align_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(st.loadReq) && !addrErr) |-> (wrPtr % C_BWORDS == '0));

  // R9: a cancelling edge returns the pointer to word 0
  p_cancel_zero_r9: assert property (@(posedge clk) disable iff (rst)
    $past(st.stdReset) |-> (wrPtr == '0));
endmodule

// File: rtl/blk_addr_loader.sv
module blk_addr_loader
  import blk_addr_pkg::*;
#(
  parameter int ADDR_W         = 13,
  parameter int FIRST_BIT_EDGE = 5,
  parameter int LAT_CYCLES     = 18,
  parameter int BLOCK_WORDS    = 40,
  parameter int NUM_BLOCKS     = 6144,
  parameter int PTR_W          = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrRst,
  input  logic             we,
  input  logic             ie,
  input  logic             d0,
  output logic             busy,
  output logic             pinSelIe,
  output logic             timingViol,
  output logic             addrErr,
  output logic [PTR_W-1:0] wrPtr
);
  ctrlStrobes_t st;

  blk_addr_ctrl #(
    .ADDR_W(ADDR_W), .FIRST_BIT_EDGE(FIRST_BIT_EDGE), .LAT_CYCLES(LAT_CYCLES)
  ) i_ctrl (
    .clk(clk), .rst(rst), .wrRst(wrRst), .we(we), .ie(ie), .d0(d0),
    .st(st), .busy(busy), .pinSelIe(pinSelIe), .timingViol(timingViol)
  );

  blk_addr_dpath #(
    .ADDR_W(ADDR_W), .BLOCK_WORDS(BLOCK_WORDS),
    .NUM_BLOCKS(NUM_BLOCKS), .PTR_W(PTR_W)
  ) i_dpath (
    .clk(clk), .rst(rst), .st(st), .wrPtr(wrPtr), .addrErr(addrErr)
  );
endmodule

// File: tb/test_blk_addr_loader.sv
`timescale 1ns/1ps
module test_blk_addr_loader;
  localparam int LAST_WORD = 245759;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrRst = 1'b0, we = 1'b0, ie = 1'b0, d0 = 1'b0;
  logic busy, pinSelIe, timingViol, addrErr;
  logic [17:0] wrPtr;

  int nChecks = 0;
  int nErr = 0;
  int ptrModel = 0;
  bit errModel = 1'b0;
  bit done = 1'b0;

  blk_addr_loader i_blk_addr_loader (
    .clk(clk), .rst(rst), .wrRst(wrRst), .we(we), .ie(ie), .d0(d0),
    .busy(busy), .pinSelIe(pinSelIe), .timingViol(timingViol),
    .addrErr(addrErr), .wrPtr(wrPtr)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive at posedge+2, then wait for the edge and let outputs settle.
  task automatic step(input logic r, input logic w, input logic i, input logic d);
    wrRst = r; we = w; ie = i; d0 = d;
    @(posedge clk);
    #2;
  endtask

  function automatic bit rbit();
    return 1'($urandom % 2);
  endfunction

  function automatic bit vioExpected(bit modeIe, int e, bit w, bit early);
    if (!modeIe && e == 5 && early) return 1'b1;
    if (!modeIe && e >= 6 && e <= 34 && w) return 1'b1;
    if (modeIe && e >= 7 && e <= 34 && w) return 1'b1;
    return 1'b0;
  endfunction

  task automatic idle(input int n, input int wePct);
    for (int k = 0; k < n; k++) begin
      bit w;
      w = (($urandom % 100) < wePct);
      step(1'b0, w, rbit(), rbit());
      if (w) ptrModel = (ptrModel == LAST_WORD) ? 0 : ptrModel + 1;
      chk("R10 idle pointer", int'(wrPtr), ptrModel);
      chk("R2 idle busy", int'(busy), 0);
      chk("R6 error hold", int'(addrErr), int'(errModel));
    end
  endtask

  task automatic runSeq(input bit modeIe, input int addr, input int vioPct, input int abortAt);
    bit early;
    int ptrBefore;
    early = 1'b0;
    ptrBefore = ptrModel;
    for (int e = 1; e <= 35; e++) begin
      logic r, w, i, d;
      bit vx;
      r = (e == 1) || (e == abortAt);
      i = rbit(); d = rbit(); w = rbit();
      if (e >= 5 && e <= 17) begin
        if (modeIe) i = 1'((addr >> (17 - e)) & 1);
        else        d = 1'((addr >> (17 - e)) & 1);
      end
      if (e == 5) w = modeIe;
      else if (e == 3 || e == 4) w = modeIe ? rbit() : (($urandom % 100) < vioPct);
      else if (e == 6 && modeIe) w = rbit();
      else if (e >= 6 && e <= 34) w = (($urandom % 100) < vioPct);
      step(r, w, i, d);
      if (e == abortAt) begin
        ptrModel = 0;
        errModel = 1'b0;
        chk("R9 cancel busy", int'(busy), 0);
        chk("R9 cancel pointer", int'(wrPtr), 0);
        chk("R9 cancel no pulse", int'(timingViol), 0);
        chk("R9 cancel error", int'(addrErr), 0);
        return;
      end
      if ((e == 3 || e == 4) && w) early = 1'b1;
      vx = vioExpected(modeIe, e, w, early);
      if (modeIe) chk("R8 violation pulse", int'(timingViol), int'(vx));
      else        chk("R7 violation pulse", int'(timingViol), int'(vx));
      if (e < 35) begin
        chk("R2 busy in sequence", int'(busy), 1);
        chk("R11 pointer frozen", int'(wrPtr), ptrBefore);
      end
      if (e == 1) chk("R6 error cleared at start", int'(addrErr), 0);
      if (e >= 5) chk("R3 pin select", int'(pinSelIe), int'(modeIe));
    end
    chk("R2 busy after latency", int'(busy), 0);
    if (addr < 6144) begin
      ptrModel = addr * 40;
      errModel = 1'b0;
      chk("R4 R5 block load", int'(wrPtr), ptrModel);
    end else begin
      errModel = 1'b1;
      chk("R6 no load on bad block", int'(wrPtr), ptrModel);
    end
    chk("R6 error flag", int'(addrErr), int'(errModel));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nErr++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(posedge clk);
    #2;
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 pointer in reset", int'(wrPtr), 0);
    step(1'b0, 1'b1, 1'b1, 1'b1);
    rst = 1'b0;
    chk("R1 pinSel", int'(pinSelIe), 0);
    chk("R1 violation", int'(timingViol), 0);
    chk("R1 error", int'(addrErr), 0);

    idle(5, 60);
    runSeq(1'b0, 2650, 0, 0);
    idle(3, 50);
    runSeq(1'b1, 6143, 0, 0);          // last valid block
    idle(45, 100);                     // walk past the top: wrap to 0
    runSeq(1'b0, 6144, 0, 0);          // first invalid block
    idle(4, 50);
    runSeq(1'b1, 8191, 0, 0);
    idle(2, 0);
    runSeq(1'b0, 0, 0, 0);
    runSeq(1'b0, 1234, 30, 0);         // window violations, d0 mode
    idle(1, 0);
    runSeq(1'b1, 4321, 30, 0);         // window violations, ie mode
    idle(2, 50);
    runSeq(1'b1, 777, 0, 10);          // cancel mid-address
    idle(2, 50);
    runSeq(1'b0, 99, 0, 35);           // cancel at the load edge
    idle(2, 50);

    for (int s = 0; s < 60; s++) begin
      int ab;
      ab = (($urandom % 6) == 0) ? 3 + int'($urandom % 33) : 0;
      runSeq(rbit(), int'($urandom % 8192), int'($urandom % 3) * 10, ab);
      idle(1 + int'($urandom % 5), 50);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule